// File: doc/BRIEF.md
# Programmable Eight-Input Interrupt Controller

This block collects eight interrupt request lines and presents one interrupt output to a processor. It also supplies an 8-bit vector for the request it has chosen. Software reaches it over a byte-wide bus that has a single address bit and separate write and read strobes. After reset, or whenever software wants to reconfigure, it writes a start word and then one to three setup words. Later writes are operational commands. They change the mask, end an interrupt (with or without rotating priority), pick which register a read returns, start a poll, or turn special mask mode on and off.

Inside, the block holds a pending-request register, an in-service register and a mask register. A resolver picks the most urgent pending line, either in a fixed order or in a rotating order. The processor takes the vector by pulsing an acknowledge input for one cycle. During that cycle it reads the vector from the vector output. Fields that belong to multi-device chaining and to bus buffer control are accepted during setup and then discarded.

Top module: `irq_ctrl8`

## Requirements
- R1: After reset the mask and both status registers read zero, the interrupt output is low, priority is fixed with line 0 highest and line 7 lowest, and the controller is ready for operational commands.
- R2: A write at address 0 with data bit 4 set starts setup and clears mask, in-service, pending, special mask mode and read selection. Its bit 0 = 1 requests a fourth word, bit 1 = 0 requests a third word (chaining), and bit 3 = 1 selects level-sensitive lines. The next address-1 writes are taken in order as word 2, then word 3 only if requested, then word 4 only if requested. After that, address-1 writes set the mask.
- R3: Word 2 bits 7:3 form the vector base. While acknowledge is high, the vector output equals base in bits 7:3 and the granted line number in bits 2:0, and that line's in-service bit becomes set.
- R4: Address-1 reads return the mask, and address-1 writes outside setup replace it. A set mask bit n keeps line n from raising the interrupt output but does not stop it from being latched as pending.
- R5: In edge mode a rising line sets its pending bit, which holds until the line is granted. In level mode the pending register copies the lines every cycle, one cycle late.
- R6: Outside special mask mode, the interrupt output is high only when an unmasked pending line ranks strictly above every in-service line.
- R7: Address-0 writes with bits 4:3 = 00 are end commands: bit 5 ends, bit 6 means specific, bit 7 rotates, and bits 2:0 give a level. A non-specific end clears the highest-ranked in-service bit. A specific end clears the named bit.
- R8: An end command with bit 7 set makes the cleared line the lowest rank. A command with bits 7 and 6 set and bit 5 clear makes the level in bits 2:0 the lowest rank. In both cases the next line around the ring becomes highest.
- R9: Address-0 writes with bits 4:3 = 01 are read commands. If bit 1 is set, bit 0 chooses what later address-0 reads return: in-service (1) or pending (0).
- R10: A read command with bit 2 set arms a poll. The next address-0 read returns bit 7 = 1 and the winning line in bits 2:0, or 0x00 if no line is eligible, and it grants that line as an acknowledge would. Later reads return the selected register again.
- R11: A read command with bit 6 set loads special mask mode from bit 5. In that mode any unmasked pending line that is not in service may interrupt, and in-service bits of other lines do not block it.
- R12: Word 4 bit 1 = 1 selects automatic end: a grant leaves the in-service register unchanged.
- R13: An acknowledge with no eligible line returns base with 7 in bits 2:0 and changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 1 | Register address bit |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_din | input | 8 | Write data |
| bus_dout | output | 8 | Read data, valid while bus_rd is high |
| irq_in | input | 8 | Request lines, active high |
| ack_in | input | 1 | Acknowledge pulse, one cycle |
| int_out | output | 1 | Interrupt request to the processor |
| vec_out | output | 8 | Vector, valid while ack_in is high |

## Verification
A wrong priority pointer or a wrong in-service bit shows up at the next acknowledge, because the vector names the wrong line. It also shows up in the interrupt output as soon as a lower-ranked line is pending while a higher one is in service. A setup sequence that takes the wrong number of words lets a later word land in the mask, and the next mask read exposes it. A stale pending bit shows up in the cycle after the command that selects the pending register for reading. A cycle-accurate reference model of the registers runs beside the design, so any of these faults is caught in the first cycle where it reaches a port.

// File: rtl/pic_pkg.sv
package pic_pkg;
  parameter int unsigned NLINE = 8;
  parameter int unsigned DW    = 8;
  localparam int unsigned LW   = $clog2(NLINE);
  localparam int unsigned BW   = DW - LW;

  typedef enum logic [1:0] {SEQ_IDLE, SEQ_W2, SEQ_W3, SEQ_W4} seq_e;

  typedef struct packed {
    logic          found;
    logic [LW-1:0] lvl;
  } pick_t;

  // Most urgent set bit, scanning from the line just above 'low' round the ring.
  function automatic pick_t pick_top(input logic [NLINE-1:0] v, input logic [LW-1:0] low);
    pick_t r;
    logic [LW-1:0] idx;
    r = '0;
    for (int i = NLINE; i >= 1; i--) begin
      idx = low + LW'(i);
      if (v[idx]) begin
        r.found = 1'b1;
        r.lvl   = idx;
      end
    end
    return r;
  endfunction

  // Rank 0 is the most urgent line.
  function automatic logic [LW-1:0] rank_of(input logic [LW-1:0] lvl, input logic [LW-1:0] low);
    return lvl - low - LW'(1);
  endfunction
endpackage

// File: rtl/pic_ctl.sv
module pic_ctl import pic_pkg::*; (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             addr,
  input  logic             wr,
  input  logic             rd,
  input  logic [DW-1:0]    din,
  output logic             init_go,
  output logic             ocw2_go,
  output logic             level_mode,
  output logic             aeoi,
  output logic [BW-1:0]    base,
  output logic [NLINE-1:0] imr,
  output logic             smm,
  output logic             rd_isr,
  output logic             poll,
  output logic             poll_read
);
  seq_e seq;
  logic chain, want_w4;
  logic w0, w1, ocw3_go;

  assign w0        = wr & ~addr;
  assign w1        = wr & addr;
  assign init_go   = w0 & din[4];
  assign ocw2_go   = w0 & (din[4:3] == 2'b00);
  assign ocw3_go   = w0 & (din[4:3] == 2'b01);
  assign poll_read = rd & ~addr & poll;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seq        <= SEQ_IDLE;
      chain      <= 1'b0;
      want_w4    <= 1'b0;
      level_mode <= 1'b0;
      aeoi       <= 1'b0;
      base       <= '0;
      imr        <= '0;
      smm        <= 1'b0;
      rd_isr     <= 1'b0;
      poll       <= 1'b0;
    end else if (init_go) begin
      seq        <= SEQ_W2;
      level_mode <= din[3];
      chain      <= ~din[1];
      want_w4    <= din[0];
      aeoi       <= 1'b0;
      imr        <= '0;
      smm        <= 1'b0;
      rd_isr     <= 1'b0;
      poll       <= 1'b0;
    end else begin
      if (w1) begin
        unique case (seq)
          SEQ_W2: begin
            base <= din[DW-1:LW];
            seq  <= chain ? SEQ_W3 : (want_w4 ? SEQ_W4 : SEQ_IDLE);
          end
          SEQ_W3: seq <= want_w4 ? SEQ_W4 : SEQ_IDLE;
          SEQ_W4: begin
            aeoi <= din[1];
            seq  <= SEQ_IDLE;
          end
          default: imr <= din[NLINE-1:0];
        endcase
      end
      if (ocw3_go) begin
        if (din[1]) rd_isr <= din[0];
        if (din[6]) smm <= din[5];
        poll <= din[2];
      end else if (rd & ~addr) begin
        poll <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/pic_prio.sv
module pic_prio import pic_pkg::*; (
  input  logic [NLINE-1:0] irr,
  input  logic [NLINE-1:0] isr,
  input  logic [NLINE-1:0] imr,
  input  logic [LW-1:0]    low,
  input  logic             smm,
  output pick_t            win,
  output pick_t            isr_top,
  output logic             go
);
  logic [NLINE-1:0] cand;

  always_comb begin
    cand    = irr & ~imr & (smm ? ~isr : {NLINE{1'b1}});
    win     = pick_top(cand, low);
    isr_top = pick_top(isr, low);
    go      = win.found &
              (smm | ~isr_top.found | (rank_of(win.lvl, low) < rank_of(isr_top.lvl, low)));
  end
endmodule

// File: rtl/pic_state.sv
module pic_state import pic_pkg::*; (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NLINE-1:0] irq_in,
  input  logic             init_go,
  input  logic             level_mode,
  input  logic             aeoi,
  input  logic             take,
  input  logic [LW-1:0]    take_lvl,
  input  logic             ocw2_go,
  input  logic [DW-1:0]    din,
  input  pick_t            isr_top,
  output logic [NLINE-1:0] irr,
  output logic [NLINE-1:0] isr,
  output logic [LW-1:0]    low,
  output logic [NLINE-1:0] eoi_clr
);
  logic [NLINE-1:0] prev, rise, take_mask;
  logic [LW-1:0]    clr_lvl;
  logic             clr_ok, set_pri;

  always_comb begin
    rise      = irq_in & ~prev;
    take_mask = take ? (NLINE'(1) << take_lvl) : '0;
    clr_lvl   = din[6] ? din[LW-1:0] : isr_top.lvl;
    clr_ok    = ocw2_go & din[5] & (din[6] | isr_top.found);
    eoi_clr   = clr_ok ? (NLINE'(1) << clr_lvl) : '0;
    set_pri   = ocw2_go & ~din[5] & din[7] & din[6];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev <= '0;
      irr  <= '0;
      isr  <= '0;
      low  <= LW'(NLINE - 1);
    end else begin
      prev <= irq_in;
      if (init_go) begin
        irr <= '0;
        isr <= '0;
        low <= LW'(NLINE - 1);
      end else begin
        irr <= level_mode ? irq_in : ((irr & ~take_mask) | rise);
        isr <= (isr & ~eoi_clr) | (aeoi ? '0 : take_mask);
        if (clr_ok & din[7]) low <= clr_lvl;
        else if (set_pri)    low <= din[LW-1:0];
      end
    end
  end
endmodule

// File: rtl/irq_ctrl8.sv
module irq_ctrl8 import pic_pkg::*; (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_addr,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [DW-1:0]    bus_din,
  output logic [DW-1:0]    bus_dout,
  input  logic [NLINE-1:0] irq_in,
  input  logic             ack_in,
  output logic             int_out,
  output logic [DW-1:0]    vec_out
);
  logic             init_go, ocw2_go, level_mode, aeoi, smm, rd_isr, poll, poll_read;
  logic [BW-1:0]    base;
  logic [NLINE-1:0] imr, irr, isr, eoi_clr;
  logic [LW-1:0]    low, win_lvl;
  pick_t            win, isr_top;
  logic             go, take;
  logic [DW-1:0]    poll_byte;

  pic_ctl u_ctl (
    .clk(clk), .rst_n(rst_n), .addr(bus_addr), .wr(bus_wr), .rd(bus_rd), .din(bus_din),
    .init_go(init_go), .ocw2_go(ocw2_go), .level_mode(level_mode), .aeoi(aeoi),
    .base(base), .imr(imr), .smm(smm), .rd_isr(rd_isr), .poll(poll), .poll_read(poll_read)
  );

  pic_prio u_prio (
    .irr(irr), .isr(isr), .imr(imr), .low(low), .smm(smm),
    .win(win), .isr_top(isr_top), .go(go)
  );

  assign win_lvl = win.lvl;
  assign take    = (ack_in | poll_read) & go;

  pic_state u_state (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .init_go(init_go),
    .level_mode(level_mode), .aeoi(aeoi), .take(take), .take_lvl(win_lvl),
    .ocw2_go(ocw2_go), .din(bus_din), .isr_top(isr_top),
    .irr(irr), .isr(isr), .low(low), .eoi_clr(eoi_clr)
  );

  always_comb begin
    int_out   = go;
    vec_out   = ack_in ? {base, (go ? win_lvl : LW'(NLINE - 1))} : '0;
    poll_byte = {go, {(DW-LW-1){1'b0}}, (go ? win_lvl : LW'(0))};
    if (bus_addr)    bus_dout = imr;
    else if (poll)   bus_dout = poll_byte;
    else if (rd_isr) bus_dout = isr;
    else             bus_dout = irr;
  end
endmodule

// File: rtl/pic_chk.sv
module pic_chk import pic_pkg::*; (
  input logic             clk,
  input logic             rst_n,
  input logic             wr,
  input logic             int_o,
  input logic [NLINE-1:0] irr,
  input logic [NLINE-1:0] isr,
  input logic [NLINE-1:0] imr,
  input logic             take,
  input logic [LW-1:0]    take_lvl,
  input logic             aeoi,
  input logic             level_mode,
  input logic [NLINE-1:0] irq_in,
  input logic [NLINE-1:0] eoi_clr
);
  // R4
  mask_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int_o |-> ((irr & ~imr) != '0));

  // R3
  grant_marks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !aeoi && !wr) |=> isr[$past(take_lvl)]);

  // R12
  auto_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && aeoi && !wr) |=> (isr == $past(isr)));

  // R5
  level_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (level_mode && !wr) |=> (irr == $past(irq_in)));

  // R5
  edge_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!level_mode && !wr && !take) |=> ((irr & $past(irr)) == $past(irr)));

  // R7
  end_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((eoi_clr != '0) && !take) |=> ((isr & $past(eoi_clr)) == '0));
endmodule

bind irq_ctrl8 pic_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr(bus_wr), .int_o(int_out), .irr(irr), .isr(isr),
  .imr(imr), .take(take), .take_lvl(win_lvl), .aeoi(aeoi), .level_mode(level_mode),
  .irq_in(irq_in), .eoi_clr(eoi_clr)
);

// File: tb/sim_irq_ctrl8.sv
`timescale 1ns/1ps
module sim_irq_ctrl8;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       a = 1'b0, w = 1'b0, r = 1'b0, k = 1'b0;
  logic [7:0] d = 8'h00, req = 8'h00, req_nxt = 8'h00;
  logic [7:0] dout, vec;
  logic       intr;
  int         total = 0, bad = 0;
  logic [7:0] o_dout, o_vec;
  logic       o_int;

  // reference model state
  int         m_seq, m_low;
  logic       m_cas, m_w4, m_lvl, m_aeoi, m_smm, m_risr, m_poll;
  logic [4:0] m_base;
  logic [7:0] m_imr, m_irr, m_isr, m_prev;

  always #2 clk = ~clk;

  irq_ctrl8 u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(a), .bus_wr(w), .bus_rd(r), .bus_din(d),
    .bus_dout(dout), .irq_in(req), .ack_in(k), .int_out(intr), .vec_out(vec)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic int ring_top(input logic [7:0] v, input int low);
    for (int s = 1; s <= 8; s++) if (v[(low + s) % 8]) return (low + s) % 8;
    return -1;
  endfunction

  function automatic int ring_rank(input int lv, input int low);
    return (lv - low + 7) % 8;
  endfunction

  function automatic int m_winner();
    logic [7:0] c;
    int wl, tl;
    c = m_irr & ~m_imr;
    if (m_smm) c = c & ~m_isr;
    wl = ring_top(c, m_low);
    if (wl < 0 || m_smm) return wl;
    tl = ring_top(m_isr, m_low);
    if (tl < 0) return wl;
    return (ring_rank(wl, m_low) < ring_rank(tl, m_low)) ? wl : -1;
  endfunction

  task automatic m_reset();
    m_seq = 0; m_low = 7; m_cas = 0; m_w4 = 0; m_lvl = 0; m_aeoi = 0; m_smm = 0;
    m_risr = 0; m_poll = 0; m_base = 0; m_imr = 0; m_irr = 0; m_isr = 0; m_prev = 0;
  endtask

  task automatic cyc(input logic ia, input logic iw, input logic ir, input logic [7:0] id, input logic ik);
    int wl, cl, tl;
    logic tk;
    logic [7:0] rise, tm, cm, ed;
    @(negedge clk);
    a = ia; w = iw; r = ir; d = id; k = ik; req = req_nxt;
    #1;
    o_dout = dout; o_vec = vec; o_int = intr;
    wl = m_winner();
    chk("R6 int", {7'd0, intr}, {7'd0, wl >= 0});
    if (ik) chk(wl >= 0 ? "R3 vec" : "R13 vec", vec, {m_base, (wl >= 0 ? wl[2:0] : 3'd7)});
    if (ir) begin
      if (ia) ed = m_imr;
      else if (m_poll) ed = {wl >= 0, 4'd0, (wl >= 0 ? wl[2:0] : 3'd0)};
      else if (m_risr) ed = m_isr;
      else ed = m_irr;
      chk(ia ? "R4 read" : (m_poll ? "R10 read" : (m_risr ? "R9 read" : "R5 read")), dout, ed);
    end
    @(posedge clk);
    tk = (ik || (ir && !ia && m_poll)) && wl >= 0;
    rise = req & ~m_prev;
    m_prev = req;
    if (iw && !ia && id[4]) begin
      m_seq = 1; m_lvl = id[3]; m_cas = !id[1]; m_w4 = id[0]; m_aeoi = 0; m_imr = 0;
      m_smm = 0; m_risr = 0; m_poll = 0; m_irr = 0; m_isr = 0; m_low = 7;
    end else begin
      tm = tk ? 8'(1 << wl) : 8'h00;
      cm = 8'h00;
      tl = ring_top(m_isr, m_low);
      if (iw && !ia && id[4:3] == 2'b00) begin
        if (id[5]) begin
          cl = id[6] ? int'(id[2:0]) : tl;
          if (cl >= 0) begin
            cm = 8'(1 << cl);
            if (id[7]) m_low = cl;
          end
        end else if (id[7] && id[6]) m_low = int'(id[2:0]);
      end
      m_irr = m_lvl ? req : ((m_irr & ~tm) | rise);
      m_isr = (m_isr & ~cm) | (m_aeoi ? 8'h00 : tm);
      if (iw && ia) begin
        case (m_seq)
          1: begin m_base = id[7:3]; m_seq = m_cas ? 2 : (m_w4 ? 3 : 0); end
          2: m_seq = m_w4 ? 3 : 0;
          3: begin m_aeoi = id[1]; m_seq = 0; end
          default: m_imr = id;
        endcase
      end
      if (iw && !ia && id[4:3] == 2'b01) begin
        if (id[1]) m_risr = id[0];
        if (id[6]) m_smm = id[5];
        m_poll = id[2];
      end else if (ir && !ia) m_poll = 0;
    end
  endtask

  task automatic idle();              cyc(0, 0, 0, 8'h00, 0); endtask
  task automatic wr0(input logic [7:0] v); cyc(0, 1, 0, v, 0); endtask
  task automatic wr1(input logic [7:0] v); cyc(1, 1, 0, v, 0); endtask
  task automatic rd0();               cyc(0, 0, 1, 8'h00, 0); endtask
  task automatic rd1();               cyc(1, 0, 1, 8'h00, 0); endtask
  task automatic ackc();              cyc(0, 0, 0, 8'h00, 1); endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #800000;
    bad++;
    $display("FAIL watchdog act=hung exp=done");
    summary();
  end

  initial begin
    int op;
    void'($urandom(32'h5eed1234));
    m_reset();
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R1 reset state
    rd1(); chk("R1 mask", o_dout, 8'h00);
    rd0(); chk("R1 pending", o_dout, 8'h00);
    chk("R1 int", {7'd0, o_int}, 8'h00);

    // R2 chained setup takes word 3, so it never reaches the mask
    wr0(8'h11); wr1(8'h20); wr1(8'h55); wr1(8'h01);
    rd1(); chk("R2 w3 skipped mask", o_dout, 8'h00);
    // R2 single, no word 4: the third write is the mask
    wr0(8'h1A); wr1(8'h20); wr1(8'h0F);
    rd1(); chk("R2 mask after w2", o_dout, 8'h0F);
    // R5 level mode follows the lines
    req_nxt = 8'h40; idle();
    rd0(); chk("R5 level set", o_dout, 8'h40);
    req_nxt = 8'h00; idle();
    rd0(); chk("R5 level clear", o_dout, 8'h00);

    // edge mode, base 0x48, word 4 without automatic end
    wr0(8'h13); wr1(8'h48); wr1(8'h01);
    req_nxt = 8'h28; idle();
    ackc(); chk("R6 int raised", {7'd0, o_int}, 8'h01); chk("R3 vec 3", o_vec, 8'h4B);
    idle(); chk("R6 nested block", {7'd0, o_int}, 8'h00);
    wr0(8'h0A); rd0(); chk("R5 edge cleared", o_dout, 8'h20);
    wr0(8'h0B); rd0(); chk("R9 isr read", o_dout, 8'h08);

    // R7 end commands
    wr0(8'h20); idle(); chk("R7 nonspecific", {7'd0, o_int}, 8'h01);
    ackc(); chk("R3 vec 5", o_vec, 8'h4D);
    rd0(); chk("R9 isr 5", o_dout, 8'h20);
    wr0(8'h65); rd0(); chk("R7 specific", o_dout, 8'h00);

    // R8 rotation
    req_nxt = 8'h00; idle();
    req_nxt = 8'h01; idle();
    ackc(); chk("R3 vec 0", o_vec, 8'h48);
    wr0(8'hA0);
    req_nxt = 8'h00; idle();
    req_nxt = 8'h05; idle();
    ackc(); chk("R8 rotate end", o_vec, 8'h4A);
    wr0(8'h20);
    ackc(); chk("R8 rotated last", o_vec, 8'h48);
    wr0(8'h20);
    wr0(8'hC4);
    req_nxt = 8'h00; idle();
    req_nxt = 8'h12; idle();
    ackc(); chk("R8 set lowest", o_vec, 8'h49);
    wr0(8'h20);
    ackc(); chk("R8 set lowest next", o_vec, 8'h4C);
    wr0(8'h20); wr0(8'hC7);

    // R4 mask
    wr1(8'h04);
    req_nxt = 8'h00; idle();
    req_nxt = 8'h04; idle();
    idle(); chk("R4 masked", {7'd0, o_int}, 8'h00);
    wr0(8'h0A); rd0(); chk("R4 still latched", o_dout, 8'h04);
    rd1(); chk("R4 mask read", o_dout, 8'h04);
    wr1(8'h00); idle(); chk("R4 unmasked", {7'd0, o_int}, 8'h01);

    // R10 poll
    wr0(8'h0C); rd0(); chk("R10 poll byte", o_dout, 8'h82);
    wr0(8'h0B); rd0(); chk("R10 poll grant", o_dout, 8'h04);

    // R11 special mask mode
    req_nxt = 8'h00; idle();
    req_nxt = 8'h10; idle();
    idle(); chk("R6 blocked by 2", {7'd0, o_int}, 8'h00);
    wr1(8'h04); wr0(8'h68);
    idle(); chk("R11 smm open", {7'd0, o_int}, 8'h01);
    ackc(); chk("R11 vec", o_vec, 8'h4C);
    wr0(8'h48); wr0(8'h20); wr0(8'h20); wr1(8'h00);

    // R12 automatic end
    wr0(8'h13); wr1(8'h48); wr1(8'h03);
    req_nxt = 8'h00; idle();
    req_nxt = 8'h40; idle();
    ackc(); chk("R12 vec", o_vec, 8'h4E);
    wr0(8'h0B); rd0(); chk("R12 isr empty", o_dout, 8'h00);

    // R13 acknowledge with nothing eligible
    ackc(); chk("R13 spurious", o_vec, 8'h4F);
    rd0(); chk("R13 no change", o_dout, 8'h00);

    // constrained random against the model
    for (int n = 0; n < 4000; n++) begin
      if ($urandom_range(0, 3) == 0) req_nxt = 8'($urandom);
      op = $urandom_range(0, 99);
      if (op < 25)      idle();
      else if (op < 35) wr1(8'($urandom));
      else if (op < 47) wr0(8'($urandom) & 8'hE7);
      else if (op < 59) wr0((8'($urandom) & 8'h67) | 8'h08);
      else if (op < 69) rd0();
      else if (op < 74) rd1();
      else if (op < 98) ackc();
      else              wr0(8'($urandom) | 8'h10);
    end
    summary();
  end
endmodule